// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the tag and state side of a set-associative cache. It holds no data. Each request brings an address and a flag that marks it as a read or a write. The block divides the address into offset, set index and tag. It compares the tag against every way of the selected set and reports hit or miss. On a miss it installs the new tag, and it keeps a valid bit and a dirty bit for every line.

A separate replacement unit picks the victim way. This block shows that unit the set of the current request and takes back a victim way in the same cycle. One cycle later the block reports which way was accessed, so the unit can update its per-set state.

Two global operations work on the whole directory. A flush marks every line clean and leaves valid bits and tags as they are. An invalidate marks every line invalid.

The response arrives one cycle after the request. It tells a controller whether the line was present, which way was used, and whether an occupied line was displaced. It also reports the dirty state the selected line held before the access, which tells the controller whether a write-back is needed.

Top module: `tagdir_top`

## Requirements
- R1: The lowest OFF_W = ADDR_W - TAG_W - log2(SETS) address bits are the offset and are ignored. The next log2(SETS) bits select the set. The top TAG_W bits are the tag.
- R2: An accepted request gives resp_valid=1 one cycle later. resp_hit=1 only when a valid way of the selected set holds the request tag, and resp_way then gives that way's number in binary.
- R3: A write hit marks the line dirty, and a read hit leaves its dirty bit unchanged. resp_dirty reports the selected line's dirty bit as it stood before the access, and it reports 0 when that line was invalid.
- R4: On a miss where the set has an invalid way, the lowest-numbered invalid way is filled. The line becomes valid, its dirty bit equals the write flag, and resp_evict=0.
- R5: On a miss where every way is valid, the way given on victim_way is overwritten with the new tag. The line becomes valid, its dirty bit equals the write flag, and resp_evict=1.
- R6: Every accepted request (hit, fill or eviction) gives touch_valid=1 one cycle later, with touch_set equal to the request's set and touch_way equal to the way accessed.
- R7: flush clears every dirty bit and leaves valid bits and tags unchanged.
- R8: invalidate clears every valid bit, so the next access to any address misses.
- R9: After reset, every line is invalid and clean, and resp_valid, touch_valid and the other response outputs are 0.
- R10: invalidate has priority over flush, and flush has priority over a request. A request that arrives in the same cycle as either operation is dropped: it gives no response and changes no line.
- R11: repl_set gives, combinationally, the set index of req_addr. victim_way is sampled in the cycle the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Request address |
| flush | input | 1 | Clear all dirty bits |
| invalidate | input | 1 | Clear all valid bits |
| repl_set | output | SET_W | Set index shown to the replacement unit |
| victim_way | input | WAY_W | Victim chosen by the replacement unit |
| resp_valid | output | 1 | Response strobe, one cycle after an accepted request |
| resp_hit | output | 1 | Request hit |
| resp_evict | output | 1 | A valid line was displaced |
| resp_dirty | output | 1 | Prior dirty state of the selected line |
| resp_way | output | WAY_W | Way used |
| touch_valid | output | 1 | Access report to the replacement unit |
| touch_set | output | SET_W | Set accessed |
| touch_way | output | WAY_W | Way accessed |

## Verification
The bench fills a set in order and then evicts from it. A design that does not fill the lowest invalid way first, or that evicts while an invalid way remains, reports the wrong way or a false eviction. It also checks that a line left dirty is reported clean after it is invalidated and refilled by a read, which a design that drops the valid qualifier on resp_dirty gets wrong. A request issued together with flush or invalidate must produce no response and must leave no line installed. A later miss on that address exposes a design that serviced the request anyway. Random traffic over a small pool of tags makes hits, fills and evictions in every set, and a bench model checks every output field against it.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_ACCESS = 2'd1,
    OP_FLUSH  = 2'd2,
    OP_INVAL  = 2'd3
  } tagdir_op_e;
endpackage

// File: rtl/tagdir_array.sv
module tagdir_array
  import tagdir_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  tagdir_op_e                  op,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic                        wr_fill,
  input  logic                        wr_write,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag
);
  logic [SETS-1:0][WAYS-1:0]             valid_q, valid_d;
  logic [SETS-1:0][WAYS-1:0]             dirty_q, dirty_d;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q, tag_d;

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    tag_d   = tag_q;
    unique case (op)
      OP_INVAL: valid_d = '0;
      OP_FLUSH: dirty_d = '0;
      OP_ACCESS: begin
        if (wr_fill) begin
          tag_d[wr_set][wr_way]   = wr_tag;
          valid_d[wr_set][wr_way] = 1'b1;
          dirty_d[wr_set][wr_way] = wr_write;
        end else if (wr_write) begin
          dirty_d[wr_set][wr_way] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      tag_q   <= '0;
    end else if (op != OP_IDLE) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      tag_q   <= tag_d;
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
endmodule

// File: rtl/tagdir_lookup.sv
module tagdir_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0]             way_dirty,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [TAG_W-1:0]            req_tag,
  input  logic [WAY_W-1:0]            victim_way,
  output logic                        hit,
  output logic                        fill,
  output logic                        evict,
  output logic                        sel_dirty,
  output logic [WAY_W-1:0]            sel_way
);
  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] free_way;
  logic             all_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w])      hit_way  = WAY_W'(w);
      if (!way_valid[w]) free_way = WAY_W'(w);
    end
  end

  assign all_valid = &way_valid;
  assign hit       = |match;
  assign fill      = !hit;
  assign evict     = !hit && all_valid;
  assign sel_way   = hit ? hit_way : (all_valid ? victim_way : free_way);
  assign sel_dirty = way_valid[sel_way] && way_dirty[sel_way];
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
  import tagdir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 8,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int OFF_W = ADDR_W - TAG_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              flush,
  input  logic              invalidate,
  output logic [SET_W-1:0]  repl_set,
  input  logic [WAY_W-1:0]  victim_way,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_evict,
  output logic              resp_dirty,
  output logic [WAY_W-1:0]  resp_way,
  output logic              touch_valid,
  output logic [SET_W-1:0]  touch_set,
  output logic [WAY_W-1:0]  touch_way
);
  tagdir_op_e               op;
  logic [SET_W-1:0]         req_set;
  logic [TAG_W-1:0]         req_tag;
  logic [WAYS-1:0]          way_valid, way_dirty;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic                     lk_hit, lk_fill, lk_evict, lk_dirty;
  logic [WAY_W-1:0]         lk_way;

  logic                     rv_q, rv_d;
  logic                     rh_q, rh_d, re_q, re_d, rd_q, rd_d;
  logic [WAY_W-1:0]         rw_q, rw_d;
  logic [SET_W-1:0]         rs_q, rs_d;

  assign req_set  = req_addr[OFF_W +: SET_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign repl_set = req_set;

  always_comb begin
    if (invalidate)     op = OP_INVAL;
    else if (flush)     op = OP_FLUSH;
    else if (req_valid) op = OP_ACCESS;
    else                op = OP_IDLE;
  end

  tagdir_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .wr_set   (req_set),
    .wr_way   (lk_way),
    .wr_fill  (lk_fill),
    .wr_write (req_write),
    .wr_tag   (req_tag),
    .rd_set   (req_set),
    .rd_valid (way_valid),
    .rd_dirty (way_dirty),
    .rd_tag   (way_tag)
  );

  tagdir_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .way_valid  (way_valid),
    .way_dirty  (way_dirty),
    .way_tag    (way_tag),
    .req_tag    (req_tag),
    .victim_way (victim_way),
    .hit        (lk_hit),
    .fill       (lk_fill),
    .evict      (lk_evict),
    .sel_dirty  (lk_dirty),
    .sel_way    (lk_way)
  );

  always_comb begin
    rv_d = (op == OP_ACCESS);
    rh_d = rh_q;
    re_d = re_q;
    rd_d = rd_q;
    rw_d = rw_q;
    rs_d = rs_q;
    if (rv_d) begin
      rh_d = lk_hit;
      re_d = lk_evict;
      rd_d = lk_dirty;
      rw_d = lk_way;
      rs_d = req_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      re_q <= 1'b0;
      rd_q <= 1'b0;
      rw_q <= '0;
      rs_q <= '0;
    end else begin
      rv_q <= rv_d;
      if (rv_d) begin
        rh_q <= rh_d;
        re_q <= re_d;
        rd_q <= rd_d;
        rw_q <= rw_d;
        rs_q <= rs_d;
      end
    end
  end

  assign resp_valid  = rv_q;
  assign resp_hit    = rh_q;
  assign resp_evict  = re_q;
  assign resp_dirty  = rd_q;
  assign resp_way    = rw_q;
  assign touch_valid = rv_q;
  assign touch_set   = rs_q;
  assign touch_way   = rw_q;
endmodule

// File: rtl/tagdir_checker.sv
module tagdir_checker #(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 2,
  parameter int WAY_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              flush,
  input logic              invalidate,
  input logic [SET_W-1:0]  repl_set,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              resp_evict,
  input logic              resp_dirty,
  input logic [WAY_W-1:0]  resp_way,
  input logic              touch_valid,
  input logic [WAY_W-1:0]  touch_way
);
  logic accepted;
  assign accepted = req_valid && !flush && !invalidate;

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> resp_valid);

  assert_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accepted |=> !resp_valid);

  assert_hit_no_evict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> !resp_evict);

  assert_touch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (touch_valid && touch_way == resp_way));

  assert_inval_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(invalidate) && accepted) |=> (!resp_hit && !resp_evict && !resp_dirty));

  assert_flush_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(flush && !invalidate) && accepted) |=> !resp_dirty);

  assert_repeat_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(accepted) && accepted && req_addr == $past(req_addr))
      |=> (resp_hit && $stable(resp_way)));
endmodule

bind tagdir_top tagdir_checker #(.ADDR_W(ADDR_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .flush       (flush),
  .invalidate  (invalidate),
  .repl_set    (repl_set),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .resp_evict  (resp_evict),
  .resp_dirty  (resp_dirty),
  .resp_way    (resp_way),
  .touch_valid (touch_valid),
  .touch_way   (touch_way)
);

// File: tb/tb_tagdir_top.sv
`timescale 1ns/1ps
module tb_tagdir_top;
  localparam int ADDR_W = 16, TAG_W = 8, SETS = 4, WAYS = 4;
  localparam int SET_W = 2, WAY_W = 2, OFF_W = ADDR_W - TAG_W - SET_W;

  logic clk = 1'b0, rst_n;
  logic req_valid, req_write, flush, invalidate;
  logic [ADDR_W-1:0] req_addr;
  logic [WAY_W-1:0]  victim_way;
  logic [SET_W-1:0]  repl_set, touch_set;
  logic resp_valid, resp_hit, resp_evict, resp_dirty, touch_valid;
  logic [WAY_W-1:0]  resp_way, touch_way;

  int checks = 0, errors = 0;
  bit m_valid [SETS][WAYS];
  bit m_dirty [SETS][WAYS];
  int m_tag   [SETS][WAYS];

  always #2 clk = ~clk;

  tagdir_top #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .flush(flush), .invalidate(invalidate),
    .repl_set(repl_set), .victim_way(victim_way), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_evict(resp_evict), .resp_dirty(resp_dirty),
    .resp_way(resp_way), .touch_valid(touch_valid), .touch_set(touch_set),
    .touch_way(touch_way));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
    return ADDR_W'((tag << (OFF_W + SET_W)) | (set << OFF_W) | off);
  endfunction

  // one request with optional flush/invalidate, checked against the model
  task automatic step(input bit rv, input bit wr, input logic [ADDR_W-1:0] a,
                      input bit fl, input bit inv, input int vic);
    int set, tag, way;
    bit hit, ev, dty, acc;
    @(negedge clk);
    req_valid = rv; req_write = wr; req_addr = a;
    flush = fl; invalidate = inv; victim_way = WAY_W'(vic);
    set = int'(a[OFF_W +: SET_W]);
    tag = int'(a[ADDR_W-1 -: TAG_W]);
    acc = rv && !fl && !inv;
    #1;
    if (rv) chk("R11 repl_set", int'(repl_set), set);
    hit = 0; way = 0; ev = 0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (m_valid[set][w] && m_tag[set][w] == tag) begin hit = 1; way = w; end
    if (!hit) begin
      ev = 1;
      for (int w = WAYS - 1; w >= 0; w--)
        if (!m_valid[set][w]) begin ev = 0; way = w; end
      if (ev) way = vic;
    end
    dty = m_valid[set][way] && m_dirty[set][way];
    @(posedge clk);
    #1;
    chk("R10 resp_valid", int'(resp_valid), int'(acc));
    if (acc) begin
      chk("R2 resp_hit", int'(resp_hit), int'(hit));
      chk(hit ? "R2 resp_way" : (ev ? "R5 resp_way" : "R4 resp_way"), int'(resp_way), way);
      chk(ev ? "R5 resp_evict" : "R4 resp_evict", int'(resp_evict), int'(ev));
      chk("R3 resp_dirty", int'(resp_dirty), int'(dty));
      chk("R6 touch_valid", int'(touch_valid), 1);
      chk("R6 touch_set", int'(touch_set), set);
      chk("R6 touch_way", int'(touch_way), way);
      if (hit) begin
        if (wr) m_dirty[set][way] = 1;
      end else begin
        m_valid[set][way] = 1; m_tag[set][way] = tag; m_dirty[set][way] = wr;
      end
    end else if (inv) begin
      foreach (m_valid[s, w]) m_valid[s][w] = 0;
    end else if (fl) begin
      foreach (m_dirty[s, w]) m_dirty[s][w] = 0;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd5150);
    foreach (m_valid[s, w]) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; end
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = '0;
    flush = 0; invalidate = 0; victim_way = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 resp_valid", int'(resp_valid), 0);
    chk("R9 touch_valid", int'(touch_valid), 0);
    chk("R9 resp_hit", int'(resp_hit), 0);
    @(negedge clk); rst_n = 1'b1;
    // R9: first accesses miss into way 0; R4 fills ways in order
    for (int t = 0; t < 4; t++) step(1, t == 1, mk(t + 1, 1, 5), 0, 0, 3);
    // R1: offset ignored, same tag/set with other offsets hits
    step(1, 0, mk(3, 1, 63), 0, 0, 0);
    step(1, 0, mk(3, 2, 0), 0, 0, 0);   // other set misses (R1)
    // R3: write hit then read hit shows dirty
    step(1, 1, mk(3, 1, 0), 0, 0, 0);
    step(1, 0, mk(3, 1, 1), 0, 0, 0);
    // R5: eviction of dirty way 1 via victim
    step(1, 0, mk(9, 1, 0), 0, 0, 1);
    // R7: flush, then hit reads clean
    step(0, 0, '0, 1, 0, 0);
    step(1, 0, mk(3, 1, 0), 0, 0, 0);
    // R10: request with flush dropped, later miss proves no install
    step(1, 1, mk(7, 3, 0), 1, 0, 0);
    step(1, 1, mk(7, 3, 0), 0, 1, 0);
    step(1, 0, mk(7, 3, 0), 0, 0, 0);
    // R8: invalidate, stale dirty line refilled by read reports clean
    step(1, 1, mk(7, 3, 0), 0, 0, 0);
    step(0, 0, '0, 0, 1, 0);
    step(1, 0, mk(7, 3, 0), 0, 0, 0);
    step(1, 0, mk(7, 3, 0), 0, 0, 0);
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 90, $urandom_range(0, 1) == 1,
           mk($urandom_range(0, 6), $urandom_range(0, 3), $urandom_range(0, 63)),
           r >= 90 && r < 96, r >= 97, $urandom_range(0, 3));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule